// File: doc/BRIEF.md
# Modem Status and Loopback Register

This block gives a serial port controller its view of the four modem handshake inputs and drives its four modem handshake outputs. The raw active-low input pins for carrier detect, ring, data-set-ready and clear-to-send are synchronized. They are shown as active-high levels in the upper nibble of an 8-bit status register. The lower nibble holds sticky change flags, and a host read of the status register clears them.

A control register drives the active-low outputs data-terminal-ready, request-to-send and two auxiliary lines. A loopback enable in the same register disconnects the input pins. The control bits then feed the status levels, so software can test the status path without outside wiring. A single change output is high while any change flag is pending.

The host reaches both registers through one select line with a write strobe and a read strobe. Read data is combinational from the selected register. The clear caused by a read takes effect at the clock edge that ends the read cycle.

Top module: `modem_status_ctl`

## Requirements
- R1: After reset the status register reads 0x00, the control register reads 0x00, all four output pins are high and `changeFlag` is low.
- R2: Status bits 7, 6, 5 and 4 read 1 while `dcdN`, `riN`, `dsrN` and `ctsN` respectively are low. An input change is not visible after one rising edge and is visible after the second rising edge.
- R3: Status bits 3, 1 and 0 become 1 when the level of carrier detect, data-set-ready or clear-to-send (in that order) changes in either direction. They stay 1 until a status read clears them. The change flag appears one edge after the level does.
- R4: Status bit 2 becomes 1 only when the ring level goes from asserted to deasserted (`riN` low to high). The start of a ring sets no change flag.
- R5: A cycle with `rdEn`=1 and `regSel`=1 clears status bits 3..0 at its clock edge. It leaves bits 7..4 alone. Reading the control register (`regSel`=0) clears nothing.
- R6: A change detected in the same cycle as a clearing status read leaves its change flag set.
- R7: A write with `regSel`=0 loads the control register. Bit 0 drives `dtrN` low, bit 1 `rtsN`, bit 2 `out1N` and bit 3 `out2N`, and bit 4 enables loopback. Bits 7..5 are not stored and read back as 0.
- R8: Writing 0x08 leaves `dtrN` and `rtsN` high, 0x09 drives only `dtrN` low, and 0x0A drives only `rtsN` low.
- R9: With loopback on, the status levels come from the control bits and ignore the input pins. Request-to-send shows as clear-to-send (bit 4), terminal-ready as data-set-ready (bit 5), auxiliary 1 as ring (bit 6) and auxiliary 2 as carrier detect (bit 7). Level changes caused this way set the change flags as in R3 and R4.
- R10: `changeFlag` is high while any of status bits 3..0 is 1. It is low in the cycle after a clearing read during which no new change arrived.
- R11: A write with `regSel`=1 has no effect on the control register or the output pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctsN | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsrN | input | 1 | Data-set-ready pin, active low, asynchronous |
| riN | input | 1 | Ring pin, active low, asynchronous |
| dcdN | input | 1 | Carrier-detect pin, active low, asynchronous |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (status read clears change flags) |
| regSel | input | 1 | 0 selects the control register, 1 the status register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register |
| dtrN | output | 1 | Terminal-ready pin, active low |
| rtsN | output | 1 | Request-to-send pin, active low |
| out1N | output | 1 | Auxiliary output 1, active low |
| out2N | output | 1 | Auxiliary output 2, active low |
| changeFlag | output | 1 | High while any change flag is set |

## Verification
The assertions assume that the host strobes and `regSel` are synchronous to `clk`. The pin inputs may be asynchronous, so every property is written on the synchronized levels and never on the raw pins. The bench changes all inputs on the falling edge and holds each pin level for several cycles, so every transition reaches the edge detector. It issues reads as single-cycle pulses. For the same-cycle case, it times one read so that it falls in the cycle in which the detector sees a change.

// File: rtl/modem_pkg.sv
package modem_pkg;
  // number of modem handshake lines on each side
  localparam int LINE_CNT = 4;
  // bit positions inside the level and change vectors; the status register
  // places levels in [7:4] and change flags in [3:0] in this same order
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;
  // control register field positions
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_AUX1 = 2;
  localparam int CB_AUX2 = 3;
  localparam int CB_LOOP = 4;
  localparam int CTRL_W  = 5;

  typedef struct packed {
    logic ctrlWr;   // load control register this cycle
    logic statClr;  // status read: clear change flags at this edge
    logic selStat;  // read mux selects status register
  } strobe_t;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/modem_ctl.sv
module modem_ctl
  import modem_pkg::*;
(
  input  logic    wrEn,
  input  logic    rdEn,
  input  logic    regSel,
  output strobe_t strb
);
  always_comb begin
    strb.ctrlWr  = wrEn & ~regSel;
    strb.statClr = rdEn & regSel;
    strb.selStat = regSel;
  end
endmodule

// File: rtl/modem_dp.sv
module modem_dp
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [LINE_CNT-1:0] rawN,      // {dcdN, riN, dsrN, ctsN}
  input  logic [DATA_W-1:0]   wrData,
  output logic [LINE_CNT-1:0] ctrlPinsN, // {out2N, out1N, rtsN, dtrN}
  output logic [DATA_W-1:0]   rdData,
  output logic                anyDelta
);
  localparam int STAT_W = 2 * LINE_CNT;
  localparam int PAD_W  = DATA_W - CTRL_W;

  logic [LINE_CNT-1:0] syncN;
  logic [CTRL_W-1:0]   ctrlReg;
  logic [LINE_CNT-1:0] loopLvl;
  logic [LINE_CNT-1:0] curLvl;
  logic [LINE_CNT-1:0] prevLvl;
  logic [LINE_CNT-1:0] evt;
  logic [LINE_CNT-1:0] deltaReg;
  logic [STAT_W-1:0]   statusVal;
  logic                unusedWrBits;

  modem_sync #(
    .WIDTH  (LINE_CNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL({LINE_CNT{1'b1}})
  ) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(rawN),
    .syncOut(syncN)
  );

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (strb.ctrlWr) begin
      ctrlReg <= wrData[CTRL_W-1:0];
    end
  end
  assign unusedWrBits = ^wrData[DATA_W-1:CTRL_W];

  assign ctrlPinsN = ~ctrlReg[CB_AUX2:CB_DTR];

  // loopback routing of the control bits onto the status levels
  always_comb begin
    loopLvl          = '0;
    loopLvl[IDX_CTS] = ctrlReg[CB_RTS];
    loopLvl[IDX_DSR] = ctrlReg[CB_DTR];
    loopLvl[IDX_RI]  = ctrlReg[CB_AUX1];
    loopLvl[IDX_DCD] = ctrlReg[CB_AUX2];
  end

  assign curLvl = ctrlReg[CB_LOOP] ? loopLvl : ~syncN;

  // per-line change detection: ring reports only its trailing edge
  generate
    for (genvar i = 0; i < LINE_CNT; i++) begin : g_edge
      if (i == IDX_RI) begin : g_trail
        assign evt[i] = prevLvl[i] & ~curLvl[i];
      end else begin : g_any
        assign evt[i] = prevLvl[i] ^ curLvl[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl  <= '0;
      deltaReg <= '0;
    end else begin
      prevLvl  <= curLvl;
      deltaReg <= (deltaReg & ~{LINE_CNT{strb.statClr}}) | evt;
    end
  end

  assign statusVal = {curLvl, deltaReg};
  assign rdData    = strb.selStat ? statusVal : {{PAD_W{1'b0}}, ctrlReg};
  assign anyDelta  = |deltaReg;

  // R3
  sticky_delta_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statClr |=> ((deltaReg & $past(deltaReg)) == $past(deltaReg)));

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statClr && evt == '0) |=> (deltaReg == '0));

  // R6
  event_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt != '0) |=> ((deltaReg & $past(evt)) == $past(evt)));

  // R4
  ring_start_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curLvl[IDX_RI] && !prevLvl[IDX_RI] && !deltaReg[IDX_RI]) |=> !deltaReg[IDX_RI]);

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selStat |-> (rdData[DATA_W-1:CTRL_W] == '0));

  // R9
  loop_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[CB_LOOP] && strb.selStat) |->
      (rdData[STAT_W-1:LINE_CNT] == {~ctrlPinsN[3], ~ctrlPinsN[2], ~ctrlPinsN[0], ~ctrlPinsN[1]}));
endmodule

// File: rtl/modem_status_ctl.sv
module modem_status_ctl
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctsN,
  input  logic       dsrN,
  input  logic       riN,
  input  logic       dcdN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       regSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       dtrN,
  output logic       rtsN,
  output logic       out1N,
  output logic       out2N,
  output logic       changeFlag
);
  strobe_t             strb;
  logic [LINE_CNT-1:0] pinsN;

  modem_ctl i_ctl (
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .regSel(regSel),
    .strb  (strb)
  );

  modem_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .DATA_W     (8)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rawN     ({dcdN, riN, dsrN, ctsN}),
    .wrData   (wrData),
    .ctrlPinsN(pinsN),
    .rdData   (rdData),
    .anyDelta (changeFlag)
  );

  assign {out2N, out1N, rtsN, dtrN} = pinsN;

  // R10
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(changeFlag) |-> $past(strb.statClr));

  // R11
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel) |=> $stable(pinsN));
endmodule

// File: tb/test_modem_status_ctl.sv
module test_modem_status_ctl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctsN = 1'b1, dsrN = 1'b1, riN = 1'b1, dcdN = 1'b1;
  logic       wrEn = 1'b0, rdEn = 1'b0, regSel = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       dtrN, rtsN, out1N, out2N, changeFlag;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // {pin vector {dcdN,riN,dsrN,ctsN}, expected status}
  localparam logic [11:0] VEC [0:7] = '{
    12'hE11, 12'hC32, 12'h870, 12'hC34, 12'h4B8, 12'hF0B, 12'h0FB, 12'hF0F
  };

  always #4 clk = ~clk;

  modem_status_ctl i_modem_status_ctl (
    .clk(clk), .rstN(rstN), .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .dcdN(dcdN),
    .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel), .wrData(wrData), .rdData(rdData),
    .dtrN(dtrN), .rtsN(rtsN), .out1N(out1N), .out2N(out2N), .changeFlag(changeFlag)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic peek(logic sel, output logic [7:0] val);
    regSel = sel;
    rdEn = 1'b0;
    #1 val = rdData;
  endtask

  task automatic clearRead();
    regSel = 1'b1;
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic writeReg(logic sel, logic [7:0] d);
    regSel = sel;
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [7:0] pinByte();
    return {4'h0, dtrN, rtsN, out1N, out2N};
  endfunction

  initial begin
    logic [7:0] v;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    peek(1'b1, v); chk("R1 status", v, 8'h00);
    peek(1'b0, v); chk("R1 control", v, 8'h00);
    chk("R1 pins", pinByte(), 8'h0F);
    chk("R1 flag", {7'b0, changeFlag}, 8'h00);

    // table of pin patterns: R2 levels, R3 changes, R4 ring trailing edge, R5 clear
    for (int r = 0; r < 8; r++) begin
      {dcdN, riN, dsrN, ctsN} = VEC[r][11:8];
      tick(4);
      peek(1'b1, v); chk($sformatf("R2/R3/R4 row %0d", r), v, VEC[r][7:0]);
      clearRead();
      peek(1'b1, v); chk($sformatf("R5 row %0d", r), v, VEC[r][7:0] & 8'hF0);
    end

    // R2 synchronizer latency
    ctsN = 1'b0;
    tick(1);
    peek(1'b1, v); chk("R2 one edge", v, 8'h00);
    tick(1);
    peek(1'b1, v); chk("R2 two edges", v, 8'h10);
    tick(1);
    peek(1'b1, v); chk("R3 delta next edge", v, 8'h11);
    chk("R10 flag high", {7'b0, changeFlag}, 8'h01);

    // R6 change coinciding with the clearing read
    ctsN = 1'b1; dsrN = 1'b0;
    tick(2);
    clearRead();
    peek(1'b1, v); chk("R6 kept", v, 8'h23);
    clearRead();
    peek(1'b1, v); chk("R5 cleared", v, 8'h20);
    chk("R10 flag low", {7'b0, changeFlag}, 8'h00);
    peek(1'b0, v);
    rdEn = 1'b1; tick(1); rdEn = 1'b0;
    dsrN = 1'b1;
    tick(4);
    peek(1'b0, v);
    rdEn = 1'b1; tick(1); rdEn = 1'b0;
    peek(1'b1, v); chk("R5 control read keeps flag", v, 8'h02);
    clearRead();

    // R8 and R7 control encodings
    writeReg(1'b0, 8'h08); chk("R8 0x08 pins", pinByte(), 8'h0E);
    writeReg(1'b0, 8'h09); chk("R8 0x09 pins", pinByte(), 8'h06);
    writeReg(1'b0, 8'h0A); chk("R8 0x0A pins", pinByte(), 8'h0A);
    writeReg(1'b0, 8'hEF);
    peek(1'b0, v); chk("R7 readback", v, 8'h0F);
    chk("R7 pins", pinByte(), 8'h00);
    // R11 write to status select ignored
    writeReg(1'b1, 8'h00);
    peek(1'b0, v); chk("R11 control kept", v, 8'h0F);
    chk("R11 pins kept", pinByte(), 8'h00);
    writeReg(1'b0, 8'h00);
    tick(3);
    peek(1'b1, v); chk("R7 no loop no status", v, 8'h00);

    // R9 loopback routing
    writeReg(1'b0, 8'h15);
    {dcdN, riN, dsrN, ctsN} = 4'b0000;
    tick(4);
    peek(1'b1, v); chk("R9 loop levels", v, 8'h62);
    clearRead();
    writeReg(1'b0, 8'h10);
    tick(2);
    peek(1'b1, v); chk("R4 loop ring end", v, 8'h06);
    clearRead();
    writeReg(1'b0, 8'h00);
    tick(2);
    peek(1'b1, v); chk("R9 loop exit", v, 8'hFB);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule